// File: doc/BRIEF.md
# Serial Register-Access Control Port

This block is a slave control port that gives a host read and write access to a bank of 8-bit registers. The host uses a four-wire serial link: an active-low select, a bit clock that idles low, a data line into the port and a data line out of it. Each frame starts with a header byte. The header's upper seven bits must equal the port's device address, and its last bit selects the direction. A write frame then carries a pointer byte, followed by zero or more data bytes. Each data byte is handed to the register file as a one-cycle write strobe. A read frame carries only the header. After it, the port shifts out the register that the stored pointer selects.

The pointer byte has two fields. Bit 7 is the auto-increment flag and bits 6:0 are the register index. With the flag set, the index steps by one (modulo 128) after every byte transferred. With the flag clear, every byte goes to or comes from the same register. To read a register, the host first sends a write frame that ends right after the pointer byte, and then sends a read frame.

The serial inputs are oversampled by the system clock `clk_i` through synchronizers, so all logic runs in one clock domain. The serial bit clock half-period must be at least 8 system clock cycles. The data-out line is modelled as a value `sdo_o` plus an enable `sdo_oe_o`. The pad drives only while the enable is high.

Top module: `spi_ctrl_port`

## Requirements
- R1: Data-in is sampled on rising bit-clock edges. Data-out changes only after falling bit-clock edges and stays constant while the bit clock is high.
- R2: A frame is accepted only if the first seven bits after select falls, sent MSB first, equal 7'b1001111.
- R3: The eighth bit of the header selects the direction: 0 is a write frame and 1 is a read frame.
- R4: In a write frame, the byte after the header loads the pointer. Bit 7 is the auto-increment flag and bits 6:0 are the index.
- R5: Every further complete byte of a write frame produces exactly one single-cycle write strobe, carrying the current index and the byte (MSB first).
- R6: The data-out enable stays low for the whole of a write frame.
- R7: With the auto-increment flag at 0, successive bytes in a frame use the same index, for both writes and reads.
- R8: With the auto-increment flag at 1, the index advances by one after each byte and wraps from 127 to 0.
- R9: A write frame that ends right after the pointer byte writes nothing. The pointer it set is used by later read frames.
- R10: In a read frame, the enable rises and the MSB of the selected register appears after the falling edge that follows the header's eighth rising edge. The enable stays low during the header.
- R11: A read frame streams bytes back to back, MSB first. The register data is captured at each byte boundary.
- R12: A select going high ends the frame at any bit. The enable drops, the bit count resets, a partial data byte is discarded without a strobe, and a complete pointer byte is kept.
- R13: A header whose address does not match issues no strobe, leaves the pointer unchanged and keeps the enable low until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial bit clock, idle low |
| sdi_i | input | 1 | Serial data into the port |
| sdo_o | output | 1 | Serial data out of the port |
| sdo_oe_o | output | 1 | Drive enable for the data-out pad |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_waddr_o | output | 7 | Register index for the write strobe |
| reg_wdata_o | output | 8 | Data for the write strobe |
| reg_raddr_o | output | 7 | Register index for read data |
| reg_rdata_i | input | 8 | Read data for `reg_raddr_o`, combinational |

## Verification
The checker watches the following on every cycle:
- the write strobe never lasts more than one cycle;
- the data-out enable is high only in the read state, and only after a falling bit-clock edge;
- an ignored frame produces neither strobes nor drive;
- a high select clears the drive and the bit count;
- at each strobe, the index has moved by exactly one or not at all, as the flag requires.

Some behaviour can only be shown by the bench's scenarios:
- that the header address is actually compared;
- that a pointer-only frame steers a later read;
- the wrap from 127 to 0;
- that an aborted byte is discarded while a complete pointer survives;
- the bit-exact content of streamed reads, checked against a register model after random write bursts.

// File: rtl/spi_cp_pkg.sv
package spi_cp_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = BYTE_W - 1;

  typedef struct packed {
    logic             inc;
    logic [IDX_W-1:0] idx;
  } ptr_t;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_PTR,
    ST_WDATA,
    ST_READ,
    ST_SKIP
  } cp_state_e;
endpackage

// File: rtl/spi_cp_sync.sv
module spi_cp_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[0] <= RST_VAL;
        else         pipe_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_cp_edge.sv
module spi_cp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/spi_cp_rx.sv
module spi_cp_rx
  import spi_cp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [$clog2(BYTE_W)-1:0] cnt_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
    end else if (clr_i) begin
      // partial byte dropped
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          done_o <= 1'b1;
          byte_o <= {sh_q, bit_i};
          cnt_q  <= '0;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_cp_ctrl.sv
module spi_cp_ctrl
  import spi_cp_pkg::*;
#(
  parameter logic [IDX_W-1:0] DEV_ADDR = 7'b1001111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] byte_i,
  output cp_state_e         state_o,
  output ptr_t              ptr_o,
  output logic              load_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  waddr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  cp_state_e state_q;
  ptr_t      ptr_q;

  function automatic logic [IDX_W-1:0] step(ptr_t p);
    return p.inc ? p.idx + 1'b1 : p.idx;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      ptr_q   <= '0;
      load_o  <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      load_o <= 1'b0;
      we_o   <= 1'b0;
      if (cs_i) begin
        state_q <= ST_HDR;
      end else if (done_i) begin
        unique case (state_q)
          ST_HDR: begin
            if (byte_i[BYTE_W-1:1] != DEV_ADDR) state_q <= ST_SKIP;
            else if (byte_i[0]) begin
              state_q <= ST_READ;
              load_o  <= 1'b1;
            end else state_q <= ST_PTR;
          end
          ST_PTR: begin
            ptr_q   <= ptr_t'(byte_i);
            state_q <= ST_WDATA;
          end
          ST_WDATA: begin
            we_o       <= 1'b1;
            waddr_o    <= ptr_q.idx;
            wdata_o    <= byte_i;
            ptr_q.idx  <= step(ptr_q);
          end
          ST_READ: begin
            // advance, then fetch the next byte one cycle later
            ptr_q.idx <= step(ptr_q);
            load_o    <= 1'b1;
          end
          default: state_q <= ST_SKIP;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/spi_cp_tx.sv
module spi_cp_tx
  import spi_cp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              sdo_o,
  output logic              oe_o
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_o <= 1'b0;
      oe_o  <= 1'b0;
    end else if (cs_i) begin
      sdo_o <= 1'b0;
      oe_o  <= 1'b0;
    end else if (load_i) begin
      sh_q <= data_i;
    end else if (fall_i && active_i) begin
      sdo_o <= sh_q[BYTE_W-1];
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      oe_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
  import spi_cp_pkg::*;
#(
  parameter logic [IDX_W-1:0] DEV_ADDR    = 7'b1001111,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic [IDX_W-1:0]  reg_raddr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0]        sync_q;
  logic              cs_s, sclk_s, sdi_s;
  logic              sclk_rise, sclk_fall;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [CNT_W-1:0]  bit_cnt;
  cp_state_e         state;
  ptr_t              ptr;
  logic              load;

  spi_cp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {cs_s, sclk_s, sdi_s} = sync_q;

  spi_cp_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sclk_s),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  spi_cp_rx u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cs_s),
    .rise_i(sclk_rise),
    .bit_i (sdi_s),
    .done_o(byte_done),
    .byte_o(byte_val),
    .cnt_o (bit_cnt)
  );

  spi_cp_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_s),
    .done_i (byte_done),
    .byte_i (byte_val),
    .state_o(state),
    .ptr_o  (ptr),
    .load_o (load),
    .we_o   (reg_we_o),
    .waddr_o(reg_waddr_o),
    .wdata_o(reg_wdata_o)
  );

  spi_cp_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_s),
    .fall_i  (sclk_fall),
    .active_i(state == ST_READ),
    .load_i  (load),
    .data_i  (reg_rdata_i),
    .sdo_o   (sdo_o),
    .oe_o    (sdo_oe_o)
  );

  assign reg_raddr_o = ptr.idx;
endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk
  import spi_cp_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             sclk_fall,
  input logic [$clog2(BYTE_W)-1:0] bit_cnt,
  input cp_state_e        state,
  input ptr_t             ptr,
  input logic             sdo_oe_o,
  input logic             reg_we_o,
  input logic [IDX_W-1:0] reg_waddr_o
);
  assert_we_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_oe_read_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> state == ST_READ);

  assert_oe_after_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(sclk_fall));

  assert_skip_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_SKIP |-> !reg_we_o && !sdo_oe_o);

  assert_cs_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdo_oe_o && bit_cnt == '0);

  assert_inc_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && ptr.inc |-> ptr.idx == IDX_W'(reg_waddr_o + 1'b1));

  assert_hold_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && !ptr.inc |-> ptr.idx == reg_waddr_o);
endmodule

bind spi_ctrl_port spi_ctrl_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s       (cs_s),
  .sclk_fall  (sclk_fall),
  .bit_cnt    (bit_cnt),
  .state      (state),
  .ptr        (ptr),
  .sdo_oe_o   (sdo_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_waddr_o(reg_waddr_o)
);

// File: tb/spi_ctrl_port_test.sv
module spi_ctrl_port_test;
  localparam int H = 8;
  localparam logic [7:0] HDR_WR = 8'h9E;
  localparam logic [7:0] HDR_RD = 8'h9F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, reg_we;
  logic [6:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] wl_a [512];
  logic [7:0] wl_d [512];
  int wn = 0;
  logic oe_seen;
  logic rise_mis;
  logic [7:0] rd_buf [8];

  always #2 clk = ~clk;

  spi_ctrl_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_we_o(reg_we), .reg_waddr_o(reg_waddr),
    .reg_wdata_o(reg_wdata), .reg_raddr_o(reg_raddr), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [6:0] nxt(logic [6:0] i, logic inc);
    return inc ? i + 7'd1 : i;
  endfunction

  assign reg_rdata = mem[reg_raddr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
      if (wn < 512) begin
        wl_a[wn] <= reg_waddr;
        wl_d[wn] <= reg_wdata;
      end
      wn <= wn + 1;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cwait(input int n);
    repeat (n) begin
      @(negedge clk);
      if (sdo_oe) oe_seen = 1'b1;
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    logic r2;
    sdi = b;
    cwait(H);
    r = sdo;
    sclk = 1'b1;
    cwait(H);
    r2 = sdo;
    if (r2 !== r) rise_mis = 1'b1;
    sclk = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_x(b[i], r[i]);
  endtask

  task automatic f_begin();
    oe_seen  = 1'b0;
    rise_mis = 1'b0;
    cs_n = 1'b0;
    cwait(H);
  endtask

  task automatic f_end();
    cwait(H);
    cs_n = 1'b1;
    cwait(3 * H);
  endtask

  task automatic wr_frame(input logic [7:0] hdr, input logic [7:0] ptr,
                          input int n, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3);
    logic [7:0] r;
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    f_begin();
    byte_x(hdr, r);
    byte_x(ptr, r);
    for (int k = 0; k < n; k++) byte_x(dv[k], r);
    f_end();
  endtask

  task automatic rd_frame(input logic [7:0] hdr, input int n, output logic hdr_oe);
    logic [7:0] r;
    f_begin();
    byte_x(hdr, r);
    hdr_oe = oe_seen;
    for (int k = 0; k < n; k++) begin
      byte_x(8'h00, r);
      rd_buf[k] = r;
    end
    f_end();
  endtask

  task automatic model_wr(input logic [7:0] ptr, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3);
    logic [6:0] ix;
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    ix = ptr[6:0];
    for (int k = 0; k < n; k++) begin
      exp_mem[ix] = dv[k];
      ix = nxt(ix, ptr[7]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    logic hoe;
    logic [6:0] ix;
    logic [7:0] p;
    logic [7:0] dv [4];
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    cwait(5);
    rst_n = 1'b1;
    cwait(5);

    // reset state
    check(sdo_oe === 1'b0, "R12", "idle oe", sdo_oe, 0);
    check(reg_we === 1'b0, "R5", "idle we", reg_we, 0);
    check(reg_raddr === 7'd0, "R4", "reset index", reg_raddr, 0);

    // R4 R5 R6 R7: fixed index write burst
    w0 = wn;
    wr_frame(HDR_WR, 8'h05, 2, 8'hA5, 8'h3C, 8'h00, 8'h00);
    model_wr(8'h05, 2, 8'hA5, 8'h3C, 8'h00, 8'h00);
    check(wn - w0 == 2, "R5", "strobe count", wn - w0, 2);
    check(wl_a[w0] == 7'd5 && wl_a[w0+1] == 7'd5, "R7", "held index", wl_a[w0+1], 5);
    check(wl_d[w0] == 8'hA5 && wl_d[w0+1] == 8'h3C, "R5", "write data", wl_d[w0+1], 8'h3C);
    check(oe_seen == 1'b0, "R6", "oe in write frame", oe_seen, 0);

    // R8: increment with wrap
    w0 = wn;
    wr_frame(HDR_WR, 8'hFE, 3, 8'h11, 8'h22, 8'h33, 8'h00);
    model_wr(8'hFE, 3, 8'h11, 8'h22, 8'h33, 8'h00);
    check(wn - w0 == 3, "R8", "strobe count", wn - w0, 3);
    check(wl_a[w0] == 7'd126 && wl_a[w0+1] == 7'd127 && wl_a[w0+2] == 7'd0,
          "R8", "wrap index", wl_a[w0+2], 0);

    // R9 R10 R11: pointer-only frame, then streamed read
    w0 = wn;
    wr_frame(HDR_WR, 8'hFE, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    check(wn == w0, "R9", "pointer-only strobes", wn - w0, 0);
    rd_frame(HDR_RD, 3, hoe);
    check(hoe == 1'b0, "R10", "oe during header", hoe, 0);
    check(oe_seen == 1'b1, "R10", "oe in read", oe_seen, 1);
    check(rd_buf[0] == 8'h11, "R10", "first byte", rd_buf[0], 8'h11);
    check(rd_buf[1] == 8'h22 && rd_buf[2] == 8'h33, "R11", "stream", rd_buf[2], 8'h33);
    check(rise_mis == 1'b0, "R1", "sdo stable while high", rise_mis, 0);
    check(sdo_oe == 1'b0, "R12", "oe after frame", sdo_oe, 0);

    // R7 read without increment
    wr_frame(HDR_WR, 8'h05, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    rd_frame(HDR_RD, 2, hoe);
    check(rd_buf[0] == 8'h3C && rd_buf[1] == 8'h3C, "R7", "repeat read", rd_buf[1], 8'h3C);

    // R2 R13: wrong address write
    w0 = wn;
    wr_frame(8'h9C, 8'h85, 1, 8'hFF, 8'h00, 8'h00, 8'h00);
    check(wn == w0, "R13", "mismatch strobes", wn - w0, 0);
    check(oe_seen == 1'b0, "R13", "mismatch write oe", oe_seen, 0);
    // R3 R13: wrong address with read bit
    rd_frame(8'h9D, 2, hoe);
    check(oe_seen == 1'b0, "R2", "mismatch read oe", oe_seen, 0);
    rd_frame(HDR_RD, 1, hoe);
    check(rd_buf[0] == 8'h3C, "R13", "pointer kept", rd_buf[0], 8'h3C);
    check(oe_seen == 1'b1, "R3", "read bit decoded", oe_seen, 1);

    // R12: abort mid data byte
    w0 = wn;
    f_begin();
    byte_x(HDR_WR, p);
    byte_x(8'h09, p);
    for (int i = 0; i < 5; i++) bit_x(1'b1, hoe);
    f_end();
    check(wn == w0, "R12", "partial byte dropped", wn - w0, 0);
    check(sdo_oe == 1'b0, "R12", "oe after abort", sdo_oe, 0);
    rd_frame(HDR_RD, 1, hoe);
    check(rd_buf[0] == exp_mem[9], "R12", "pointer survives abort", rd_buf[0], exp_mem[9]);

    // random bursts, read back against model
    for (int it = 0; it < 16; it++) begin
      ix = 7'($urandom_range(0, 127));
      p  = {1'($urandom_range(0, 1)), ix};
      n  = $urandom_range(1, 4);
      for (int k = 0; k < 4; k++) dv[k] = 8'($urandom);
      w0 = wn;
      wr_frame(HDR_WR, p, n, dv[0], dv[1], dv[2], dv[3]);
      model_wr(p, n, dv[0], dv[1], dv[2], dv[3]);
      check(wn - w0 == n, "R5", "random strobe count", wn - w0, n);
      wr_frame(HDR_WR, p, 0, 8'h00, 8'h00, 8'h00, 8'h00);
      rd_frame(HDR_RD, n, hoe);
      for (int k = 0; k < n; k++) begin
        check(rd_buf[k] == exp_mem[ix], "R11", "random readback", rd_buf[k], exp_mem[ix]);
        ix = nxt(ix, p[7]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule